// File: doc/BRIEF.md
# Erasable One-Time-Writable Memory Array Model

This block is a synthesizable cycle-level model of a byte-wide memory whose bits can only be cleared by writing. A full erase is the only way to set them again. Four control inputs select one of five access modes: read, standby, program, program verify and program inhibit. The inputs are an active-low chip select, an active-low output enable, an active-low program strobe and a flag that says the programming supply is present. The bidirectional data bus is split into an input word, an output word and an output-drive enable, which the surrounding logic combines into a tri-state pad.

A one-clock erase pulse, or a reset, starts a sweep that writes all ones to every word, one word per clock. A busy flag is high while the sweep runs. During the sweep the outputs are not driven and programming is ignored. Every access has one clock of latency. The output word and the drive enable are registered from the inputs sampled at the previous edge. The default depth is 1024 words (`ADDR_W = 10`). Setting `ADDR_W = 14` gives the full 16,384 x 8 organisation.

Modes are decoded from {supply flag, chip select}. Without the supply, a high select gives STANDBY and a low select gives READ. With the supply, a high select gives INHIBIT. With the supply and a low select, a low strobe gives PROG and a high strobe gives VERIFY. The erase engine has two states. In IDLE, an erase pulse moves it to SWEEP. SWEEP returns to IDLE after the last address. Reset enters SWEEP at address 0.

Top module: `uvrom_array`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits (default 10 and 8), addressed by `addr`.
- R2: After reset is released, `busy` stays high for exactly 2^ADDR_W cycles, and every word then reads 8'hFF.
- R3: An `erase` pulse while not busy raises `busy` at the next edge and holds it for exactly 2^ADDR_W cycles, after which every word reads 8'hFF. An `erase` pulse while busy does not lengthen the sweep.
- R4: With `vpp_on`=1, `ce_n`=0, `pgm_n`=0 and not busy, each clock edge replaces the addressed word with its bitwise AND with `din`. No bit ever changes from 0 to 1 this way.
- R5: With `ce_n`=1 the outputs are not driven (`dout_oe`=0) one cycle later, whatever `oe_n` is.
- R6: With `vpp_on`=0, `ce_n`=0, `oe_n`=0 and not busy, `dout_oe` is 1 and `dout` equals the addressed word one cycle later. With `oe_n`=1, `dout_oe` is 0.
- R7: With `vpp_on`=1, `ce_n`=0, `pgm_n`=1, `oe_n`=0 and not busy, the addressed word is driven one cycle later.
- R8: With `vpp_on`=1 and `ce_n`=1, no word is written and nothing is driven.
- R9: In program mode `dout_oe` is 0. With `vpp_on`=0, a low `pgm_n` writes nothing.
- R10: While `busy` is high, `dout_oe` is 0 at the next edge and program requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts an erase sweep |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| pgm_n | input | 1 | Active-low program strobe |
| vpp_on | input | 1 | Programming supply present |
| erase | input | 1 | One-clock erase request |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Data to program |
| dout | output | DATA_W | Registered read data |
| dout_oe | output | 1 | Output drive enable for the data pads |
| busy | output | 1 | Erase sweep in progress |

## Verification
The assertions check the output-drive rules on every cycle. Standby and inhibit never drive, program mode never drives, a busy array never drives, and a qualified read does drive. They also check that an accepted erase pulse raises busy. The stored contents can only be shown by the bench's scenarios. Those scenarios cover the AND-only programming, the ignored program attempts under inhibit, without supply or during a sweep, the exact length of the sweep, and the all-ones contents after reset and after erase.

// File: rtl/uvrom_pkg.sv
package uvrom_pkg;
    typedef enum logic [2:0] {
        MODE_STANDBY,
        MODE_READ,
        MODE_PROG,
        MODE_VERIFY,
        MODE_INHIBIT
    } mode_e;

    typedef enum logic {
        ENG_IDLE,
        ENG_SWEEP
    } eng_e;
endpackage

// File: rtl/uvrom_mode_dec.sv
module uvrom_mode_dec
    import uvrom_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  pgm_n,
    input  logic  vpp_on,
    output mode_e mode,
    output logic  drive_req,
    output logic  prog_req
);
    always_comb begin
        unique case ({vpp_on, ce_n})
            2'b01:   mode = MODE_STANDBY;
            2'b00:   mode = MODE_READ;
            2'b11:   mode = MODE_INHIBIT;
            default: mode = pgm_n ? MODE_VERIFY : MODE_PROG;
        endcase
    end

    always_comb begin
        drive_req = 1'b0;
        prog_req  = 1'b0;
        unique case (mode)
            MODE_READ, MODE_VERIFY: drive_req = ~oe_n;
            MODE_PROG:              prog_req  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/uvrom_erase_seq.sv
module uvrom_erase_seq
    import uvrom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase,
    output logic              busy,
    output logic              sweep_en,
    output logic [ADDR_W-1:0] sweep_addr
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    eng_e              state;
    logic [ADDR_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENG_SWEEP;
            cnt   <= '0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (erase) begin
                        state <= ENG_SWEEP;
                        cnt   <= '0;
                    end
                end
                ENG_SWEEP: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) state <= ENG_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        busy       = (state == ENG_SWEEP);
        sweep_en   = (state == ENG_SWEEP) && !rst;
        sweep_addr = cnt;
    end
endmodule

// File: rtl/uvrom_cell_array.sv
module uvrom_cell_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              sweep_en,
    input  logic [ADDR_W-1:0] sweep_addr,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (sweep_en)
            cells[sweep_addr] <= '1;
        else if (prog_en)
            cells[addr] <= cells[addr] & din;
        rd_data <= cells[addr];
    end
endmodule

// File: rtl/uvrom_array.sv
module uvrom_array
    import uvrom_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_on,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              busy
);
    mode_e             mode;
    logic              drive_req;
    logic              prog_req;
    logic              sweep_en;
    logic [ADDR_W-1:0] sweep_addr;

    uvrom_mode_dec u_dec (
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .pgm_n     (pgm_n),
        .vpp_on    (vpp_on),
        .mode      (mode),
        .drive_req (drive_req),
        .prog_req  (prog_req)
    );

    uvrom_erase_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .erase      (erase),
        .busy       (busy),
        .sweep_en   (sweep_en),
        .sweep_addr (sweep_addr)
    );

    uvrom_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
        .clk        (clk),
        .sweep_en   (sweep_en),
        .sweep_addr (sweep_addr),
        .prog_en    (prog_req && !busy && !rst),
        .addr       (addr),
        .din        (din),
        .rd_data    (dout)
    );

    always_ff @(posedge clk) begin
        if (rst) dout_oe <= 1'b0;
        else     dout_oe <= drive_req && !busy;
    end
endmodule

// File: rtl/uvrom_array_chk.sv
module uvrom_array_chk (
    input logic clk,
    input logic rst,
    input logic ce_n,
    input logic oe_n,
    input logic pgm_n,
    input logic vpp_on,
    input logic erase,
    input logic busy,
    input logic dout_oe
);
    p_standby_hiz_r5: assert property (@(posedge clk) disable iff (rst)
        (ce_n && !vpp_on) |=> !dout_oe);

    p_read_drive_r6: assert property (@(posedge clk) disable iff (rst)
        (!vpp_on && !ce_n && !oe_n && !busy) |=> dout_oe);

    p_verify_drive_r7: assert property (@(posedge clk) disable iff (rst)
        (vpp_on && !ce_n && pgm_n && !oe_n && !busy) |=> dout_oe);

    p_inhibit_hiz_r8: assert property (@(posedge clk) disable iff (rst)
        (vpp_on && ce_n) |=> !dout_oe);

    p_prog_hiz_r9: assert property (@(posedge clk) disable iff (rst)
        (vpp_on && !ce_n && !pgm_n) |=> !dout_oe);

    p_busy_hiz_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> !dout_oe);

    p_erase_start_r3: assert property (@(posedge clk) disable iff (rst)
        (erase && !busy) |=> busy);
endmodule

bind uvrom_array uvrom_array_chk u_chk (.*);

// File: tb/uvrom_array_bench.sv
module uvrom_array_bench;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct packed {
        logic        ce_n;
        logic        oe_n;
        logic        pgm_n;
        logic        vpp;
        logic [9:0]  a;
        logic [7:0]  d;
        logic        x_oe;
        logic [7:0]  x_d;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b1,1'b0,10'd5,  8'h00,1'b1,8'hFF,4'd6},  // R6 read erased word
        '{1'b1,1'b0,1'b1,1'b0,10'd5,  8'h00,1'b0,8'h00,4'd5},  // R5 standby, oe low
        '{1'b0,1'b1,1'b1,1'b0,10'd5,  8'h00,1'b0,8'h00,4'd6},  // R6 oe high
        '{1'b0,1'b1,1'b0,1'b1,10'd5,  8'hF0,1'b0,8'h00,4'd9},  // R9 program, no drive
        '{1'b0,1'b0,1'b1,1'b1,10'd5,  8'h00,1'b1,8'hF0,4'd7},  // R7 verify
        '{1'b0,1'b0,1'b0,1'b1,10'd5,  8'h3C,1'b0,8'h00,4'd4},  // R4 AND again
        '{1'b0,1'b0,1'b1,1'b1,10'd5,  8'h00,1'b1,8'h30,4'd4},  // R4 F0&3C
        '{1'b0,1'b1,1'b0,1'b1,10'd5,  8'hFF,1'b0,8'h00,4'd4},  // R4 try to set bits
        '{1'b0,1'b0,1'b1,1'b0,10'd5,  8'h00,1'b1,8'h30,4'd4},  // R4 bits stay clear
        '{1'b1,1'b0,1'b0,1'b1,10'd6,  8'h00,1'b0,8'h00,4'd8},  // R8 inhibit
        '{1'b0,1'b0,1'b1,1'b0,10'd6,  8'h00,1'b1,8'hFF,4'd8},  // R8 word 6 untouched
        '{1'b0,1'b1,1'b0,1'b0,10'd7,  8'h00,1'b0,8'h00,4'd9},  // R9 strobe without supply
        '{1'b0,1'b0,1'b1,1'b0,10'd7,  8'h00,1'b1,8'hFF,4'd9},  // R9 word 7 untouched
        '{1'b0,1'b1,1'b1,1'b1,10'd7,  8'h00,1'b0,8'h00,4'd7},  // R7 verify, oe high
        '{1'b0,1'b1,1'b0,1'b1,10'h3FF,8'h5A,1'b0,8'h00,4'd1},  // R1 top address
        '{1'b0,1'b0,1'b1,1'b0,10'h3FF,8'h00,1'b1,8'h5A,4'd1}   // R1 top address read
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_on = 1'b0, erase = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic              dout_oe, busy;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    uvrom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_uvrom_array (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .vpp_on(vpp_on), .erase(erase), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic o, input logic p, input logic v,
                         input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        ce_n = c; oe_n = o; pgm_n = p; vpp_on = v; addr = a; din = d;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp, input string tag);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, 1'b0, a, '0);
        @(negedge clk);
        chk(tag, {31'd0, dout_oe}, 32'd1);
        chk(tag, {24'd0, dout}, {24'd0, exp});
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy) begin
            @(negedge clk);
            n++;
            if (n > 4 * DEPTH) break;
        end
    endtask

    initial begin
        int n;
        // R2: reset state and sweep length
        repeat (3) @(negedge clk);
        chk("R2 reset oe", {31'd0, dout_oe}, 32'd0);
        chk("R2 reset busy", {31'd0, busy}, 32'd1);
        rst = 1'b0;
        count_busy(n);
        chk("R2 sweep length", n, DEPTH);
        chk("R10 no drive while busy", {31'd0, dout_oe}, 32'd0);
        rd(10'd0, 8'hFF, "R2 word0");
        rd(10'h3FF, 8'hFF, "R2 last word");

        // vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].ce_n, VECS[i].oe_n, VECS[i].pgm_n, VECS[i].vpp, VECS[i].a, VECS[i].d);
            @(negedge clk);
            chk($sformatf("R%0d vec%0d oe", VECS[i].req, i), {31'd0, dout_oe}, {31'd0, VECS[i].x_oe});
            if (VECS[i].x_oe)
                chk($sformatf("R%0d vec%0d data", VECS[i].req, i), {24'd0, dout}, {24'd0, VECS[i].x_d});
        end

        // R3: erase, with a second pulse and a program attempt during the sweep (R10)
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b1, 1'b0, '0, '0);
        erase = 1'b1;
        @(negedge clk);
        erase = 1'b0;
        chk("R3 busy after pulse", {31'd0, busy}, 32'd1);
        n = 1;
        repeat (DEPTH / 2) begin @(negedge clk); n++; end
        erase = 1'b1;
        drive(1'b0, 1'b1, 1'b0, 1'b1, 10'd0, 8'h00);
        @(negedge clk); n++;
        erase = 1'b0;
        drive(1'b1, 1'b1, 1'b1, 1'b0, '0, '0);
        while (busy && n < 4 * DEPTH) begin @(negedge clk); n++; end
        chk("R3 sweep length", n - 1, DEPTH);
        rd(10'd5, 8'hFF, "R3 word5 erased");
        rd(10'h3FF, 8'hFF, "R3 last word erased");
        rd(10'd0, 8'hFF, "R10 program during sweep ignored");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule